// File: doc/BRIEF.md
# Multi-queue descriptor ring controller

This block keeps the bookkeeping for a set of circular command rings that a copy engine drains. Software places 32-byte descriptors in memory and describes each ring through a small register window: a ring base address, a ring length, and a write index that it advances after filling a slot. The block holds the matching read index. It presents the memory address of the next descriptor on a fetch port and moves the read index forward once the engine acknowledges that descriptor.

Each queue has a control word with a run bit and an interrupt enable. A global register sets how many queues are live, and the value written is clamped to the supported range. When several queues have work, the fetch port serves them in round-robin order. Every queue records the reason for its interrupt in a 4-bit code: the ring drained, the queue was stopped, or the engine reported a bad descriptor. While the code is non-zero and interrupts are enabled, the queue's level interrupt line is high. Writing the status register clears the code.

Top module: `ring_ctrl`

## Requirements
- R1: After reset the queue-count register reads 1, and for every queue the control word reads 0, the length reads 32 and both indices read 0. `fetch_req` and every `irq` bit are low.
- R2: Register byte offset 0x000 holds the live queue count. A written value of 0 is stored as 1, a value above NUM_Q is stored as NUM_Q, and any other value is kept. A read returns the stored value.
- R3: Queue n (starting from 0) decodes at byte offset (n+1)*0x20. Within the window: control at +0x00, status at +0x04, length at +0x08, read index at +0x0C (read-only), write index at +0x10, base low word at +0x18, base high word at +0x1C. A write to one window leaves every other window unchanged.
- R4: A queue is ready when its number is below the count, control bit 0 (run) is 1, and its read index differs from its write index. When no request is outstanding and some queue is ready, `fetch_req` rises on the next clock edge. It carries that queue's number on `fetch_qid` and base + read_index*32 on `fetch_addr`, and holds both until `fetch_ack` is sampled high.
- R5: A clock edge with `fetch_req` and `fetch_ack` both high advances that queue's read index by one, wrapping to 0 at the ring length. `fetch_req` is low for the following cycle. No other event changes a read index.
- R6: A written length is clamped to the range 2 to 32. A write-index value that is not below the current length is ignored.
- R7: Status bit 0 reads 1 exactly when ((length + write_index − read_index) mod length) ≥ length − 1.
- R8: After queue q is acknowledged, the next grant goes to the first ready queue found when counting cyclically from q+1.
- R9: Status bits 27:24 hold the interrupt reason. The codes OR into it and stay set: 0x1 when an acknowledge leaves the read index equal to the write index, 0x2 when a control write clears bit 0 while it was 1, and 0x4 when `fetch_err` is high together with an acknowledge. Any write to the status register clears the field, but an event in the same cycle still sets its code.
- R10: `irq[q]` is high exactly when queue q is below the count, control bit 1 is 1, and the reason field is non-zero. Writing 0x7 to control enables interrupts and writing 0 disables them.
- R11: A queue numbered at or above the count is never granted, and neither is a queue whose run bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_qid | output | 4 | Queue that owns the requested descriptor |
| fetch_addr | output | 64 | Memory address of the descriptor slot |
| fetch_ack | input | 1 | Engine has taken the requested descriptor |
| fetch_err | input | 1 | Descriptor was faulty, valid with fetch_ack |
| irq | output | 16 | Level interrupt, one per queue |

## Verification
The bench checks the clamping edges of the count and length registers, and a write index equal to the length. A design that got these wrong would let software select a ring slot that does not exist. It also forces the full condition across the wrap point, where a design that compared indices directly would report the wrong fill level. The bench drives three queues at once with manual acknowledges to check the grant rotation, which a fixed-priority design would break by serving queue 1 twice in a row. It also checks that a queue above the live count, or one with its run bit cleared, is never granted, and that the empty, stop and error codes add up and clear independently of the enable bit that only masks the interrupt line.

// File: rtl/ring_pkg.sv
package ring_pkg;
   // register offsets inside one queue window
   localparam logic [4:0] OFF_CTRL = 5'h00;
   localparam logic [4:0] OFF_STAT = 5'h04;
   localparam logic [4:0] OFF_LEN  = 5'h08;
   localparam logic [4:0] OFF_RD   = 5'h0C;
   localparam logic [4:0] OFF_WR   = 5'h10;
   localparam logic [4:0] OFF_BLO  = 5'h18;
   localparam logic [4:0] OFF_BHI  = 5'h1C;
   // interrupt reason codes
   localparam logic [3:0] RSN_EMPTY = 4'h1;
   localparam logic [3:0] RSN_STOP  = 4'h2;
   localparam logic [3:0] RSN_DERR  = 4'h4;
   // control bits
   localparam int CTRL_RUN = 0;
   localparam int CTRL_IEN = 1;
endpackage

// File: rtl/ring_queue.sv
module ring_queue
   import ring_pkg::*;
#(
   parameter int RING_LEN   = 32,
   parameter int DESC_BYTES = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enabled,
   input  logic        wr_en,
   input  logic [4:0]  woff,
   input  logic [31:0] wdata,
   input  logic        done,
   input  logic        done_err,
   output logic        ready,
   output logic [$clog2(RING_LEN)-1:0] rd_idx,
   output logic [63:0] slot_addr,
   output logic [31:0] rdata,
   output logic        irq
);
   localparam int IW  = $clog2(RING_LEN);
   localparam int LW  = $clog2(RING_LEN + 1);
   localparam int DSH = $clog2(DESC_BYTES);

   logic [2:0]    ctrl;
   logic [LW-1:0] len;
   logic [IW-1:0] rd, wr, rd_nxt;
   logic [63:0]   base;
   logic [3:0]    rsn, ev;
   logic [LW-1:0] len_wr, used;
   logic          full;

   assign rd_nxt = (LW'(rd) + LW'(1) == len) ? '0 : rd + IW'(1);

   // R7: fill level computed without a divider
   assign used = (wr >= rd) ? LW'(wr) - LW'(rd) : len + LW'(wr) - LW'(rd);
   assign full = (used >= len - LW'(1));

   always_comb begin
      if (wdata < 32'd2)                 len_wr = LW'(2);
      else if (wdata > 32'(RING_LEN))    len_wr = LW'(RING_LEN);
      else                               len_wr = wdata[LW-1:0];
   end

   // R9: events raised this cycle
   always_comb begin
      ev = '0;
      if (done) begin
         if (rd_nxt == wr) ev = ev | RSN_EMPTY;
         if (done_err)     ev = ev | RSN_DERR;
      end
      if (wr_en && woff == OFF_CTRL && ctrl[CTRL_RUN] && !wdata[CTRL_RUN])
         ev = ev | RSN_STOP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         len  <= LW'(RING_LEN);
         rd   <= '0;
         wr   <= '0;
         base <= '0;
         rsn  <= '0;
      end else begin
         if (done) rd <= rd_nxt;
         if (wr_en && woff == OFF_STAT) rsn <= ev;
         else                           rsn <= rsn | ev;
         if (wr_en) begin
            case (woff)
               OFF_CTRL: ctrl <= wdata[2:0];
               OFF_LEN:  len  <= len_wr;
               OFF_WR:   if (wdata < 32'(len)) wr <= wdata[IW-1:0];
               OFF_BLO:  base[31:0]  <= wdata;
               OFF_BHI:  base[63:32] <= wdata;
               default: ;
            endcase
         end
      end
   end

   assign ready     = enabled && ctrl[CTRL_RUN] && (rd != wr);
   assign rd_idx    = rd;
   assign slot_addr = base + (64'(rd) << DSH);
   assign irq       = enabled && ctrl[CTRL_IEN] && (rsn != 4'h0);

   always_comb begin
      case (woff)
         OFF_CTRL: rdata = {29'b0, ctrl};
         OFF_STAT: rdata = {4'b0, rsn, 23'b0, full};
         OFF_LEN:  rdata = 32'(len);
         OFF_RD:   rdata = 32'(rd);
         OFF_WR:   rdata = 32'(wr);
         OFF_BLO:  rdata = base[31:0];
         OFF_BHI:  rdata = base[63:32];
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/ring_rr_arb.sv
module ring_rr_arb #(
   parameter int N  = 16,
   parameter int QW = 4
) (
   input  logic [N-1:0]  req,
   input  logic [QW-1:0] ptr,
   output logic          found,
   output logic [QW-1:0] pick
);
   generate
      if (N == 1) begin : g_single
         assign found = req[0];
         assign pick  = '0;
      end else begin : g_rotate
         // R8: search starts at ptr and wraps
         always_comb begin
            int unsigned idx;
            found = 1'b0;
            pick  = '0;
            for (int k = 0; k < N; k++) begin
               idx = (int'(ptr) + k) % N;
               if (!found && req[idx]) begin
                  found = 1'b1;
                  pick  = QW'(idx);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
   import ring_pkg::*;
#(
   parameter int NUM_Q      = 16,
   parameter int RING_LEN   = 32,
   parameter int DESC_BYTES = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  reg_we,
   input  logic [5+$clog2(NUM_Q+1)-1:0]          reg_addr,
   input  logic [31:0]                           reg_wdata,
   output logic [31:0]                           reg_rdata,
   output logic                                  fetch_req,
   output logic [((NUM_Q > 1) ? $clog2(NUM_Q) : 1)-1:0] fetch_qid,
   output logic [63:0]                           fetch_addr,
   input  logic                                  fetch_ack,
   input  logic                                  fetch_err,
   output logic [NUM_Q-1:0]                      irq
);
   localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
   localparam int CW = $clog2(NUM_Q + 1);
   localparam int AW = 5 + CW;
   localparam int IW = $clog2(RING_LEN);

   if (NUM_Q < 1 || NUM_Q > 30) begin : g_bad_nq
      $error("ring_ctrl: NUM_Q must be 1..30");
   end
   if (RING_LEN < 2) begin : g_bad_len
      $error("ring_ctrl: RING_LEN must be at least 2");
   end
   if (DESC_BYTES < 1 || (DESC_BYTES & (DESC_BYTES - 1)) != 0) begin : g_bad_desc
      $error("ring_ctrl: DESC_BYTES must be a power of two");
   end

   logic [CW-1:0] win;
   logic [4:0]    off;
   assign win = reg_addr[AW-1:5];
   assign off = reg_addr[4:0];

   logic [CW-1:0] q_cnt;
   logic          req_q;
   logic [QW-1:0] qid_q, ptr_q, pick;
   logic          found;

   logic [NUM_Q-1:0]           q_ready;
   logic [NUM_Q-1:0][IW-1:0]   q_rd;
   logic [NUM_Q-1:0][63:0]     q_slot;
   logic [NUM_Q-1:0][31:0]     q_rdata;

   // R2: clamped live queue count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_cnt <= CW'(1);
      else if (reg_we && win == '0 && off == 5'h00) begin
         if (reg_wdata == 32'd0)             q_cnt <= CW'(1);
         else if (reg_wdata > 32'(NUM_Q))    q_cnt <= CW'(NUM_Q);
         else                                q_cnt <= reg_wdata[CW-1:0];
      end
   end

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      ring_queue #(.RING_LEN(RING_LEN), .DESC_BYTES(DESC_BYTES)) u_queue (
         .clk      (clk),
         .rst_n    (rst_n),
         .enabled  (CW'(q) < q_cnt),
         .wr_en    (reg_we && win == CW'(q + 1)),
         .woff     (off),
         .wdata    (reg_wdata),
         .done     (req_q && fetch_ack && qid_q == QW'(q)),
         .done_err (fetch_err),
         .ready    (q_ready[q]),
         .rd_idx   (q_rd[q]),
         .slot_addr(q_slot[q]),
         .rdata    (q_rdata[q]),
         .irq      (irq[q])
      );
   end

   ring_rr_arb #(.N(NUM_Q), .QW(QW)) u_arb (
      .req  (q_ready),
      .ptr  (ptr_q),
      .found(found),
      .pick (pick)
   );

   // R4 R5 R8: one outstanding request, pointer moves past the served queue
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         qid_q <= '0;
         ptr_q <= '0;
      end else if (req_q) begin
         if (fetch_ack) begin
            req_q <= 1'b0;
            ptr_q <= (qid_q == QW'(NUM_Q - 1)) ? '0 : qid_q + QW'(1);
         end
      end else if (found) begin
         req_q <= 1'b1;
         qid_q <= pick;
      end
   end

   assign fetch_req  = req_q;
   assign fetch_qid  = qid_q;
   assign fetch_addr = q_slot[qid_q];

   always_comb begin
      reg_rdata = '0;
      if (win == '0) begin
         if (off == 5'h00) reg_rdata = 32'(q_cnt);
      end else begin
         for (int q = 0; q < NUM_Q; q++)
            if (win == CW'(q + 1)) reg_rdata = q_rdata[q];
      end
   end
endmodule

// File: rtl/ring_ctrl_chk.sv
module ring_ctrl_chk #(
   parameter int NUM_Q    = 16,
   parameter int RING_LEN = 32
) (
   input logic clk,
   input logic rst_n,
   input logic fetch_req,
   input logic fetch_ack,
   input logic [((NUM_Q > 1) ? $clog2(NUM_Q) : 1)-1:0] fetch_qid,
   input logic [$clog2(NUM_Q + 1)-1:0] q_cnt,
   input logic [NUM_Q-1:0][$clog2(RING_LEN)-1:0] q_rd,
   input logic [NUM_Q-1:0] irq
);
   localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
   localparam int CW = $clog2(NUM_Q + 1);

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_qid))
      else $error("request dropped or changed before acknowledge");

   assert_gap_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && fetch_ack |=> !fetch_req)
      else $error("request still high after acknowledge");

   assert_grant_in_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_req) |-> (CW'(fetch_qid) < q_cnt))
      else $error("grant to a queue above the live count");

   for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
      assert_rd_only_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !(fetch_req && fetch_ack && fetch_qid == QW'(q)) |=> $stable(q_rd[q]))
         else $error("read index moved without acknowledge");

      assert_irq_live_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
         irq[q] |-> (CW'(q) < q_cnt))
         else $error("interrupt from a queue above the live count");
   end
endmodule

bind ring_ctrl ring_ctrl_chk #(.NUM_Q(NUM_Q), .RING_LEN(RING_LEN)) u_ring_ctrl_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fetch_req(fetch_req),
   .fetch_ack(fetch_ack),
   .fetch_qid(fetch_qid),
   .q_cnt    (q_cnt),
   .q_rd     (q_rd),
   .irq      (irq)
);

// File: tb/test_ring_ctrl.sv
module test_ring_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NQ = 16;

   logic        clk, rst_n, reg_we, fetch_ack, fetch_err;
   logic [9:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        fetch_req;
   logic [3:0]  fetch_qid;
   logic [63:0] fetch_addr;
   logic [NQ-1:0] irq;

   int n_chk = 0, n_fail = 0;
   bit done = 0, auto_ack = 0, err_pending = 0;

   ring_ctrl i_ring_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
      .fetch_qid(fetch_qid), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
      .fetch_err(fetch_err), .irq(irq));

   initial begin
      clk = 0;
      forever #(CLK_PERIOD / 2) clk = ~clk;
   end

   // ---------------- behavioural reference ----------------
   int m_cnt, m_ptr, m_qid;
   bit m_req;
   int m_ctrl [NQ];
   int m_len  [NQ];
   int m_rd   [NQ];
   int m_wr   [NQ];
   int m_rsn  [NQ];
   logic [63:0] m_base [NQ];

   task automatic m_reset();
      m_cnt = 1; m_ptr = 0; m_qid = 0; m_req = 0;
      for (int q = 0; q < NQ; q++) begin
         m_ctrl[q] = 0; m_len[q] = 32; m_rd[q] = 0; m_wr[q] = 0;
         m_rsn[q] = 0; m_base[q] = '0;
      end
   endtask

   task automatic m_step();
      int g, win, off, nrd, qq;
      int ev [NQ];
      bit ack;
      ack = m_req && fetch_ack;
      g = -1;
      if (!m_req)
         for (int k = 0; k < NQ; k++) begin
            int i;
            i = (m_ptr + k) % NQ;
            if (g < 0 && i < m_cnt && (m_ctrl[i] & 1) != 0 && m_rd[i] != m_wr[i]) g = i;
         end
      for (int q = 0; q < NQ; q++) ev[q] = 0;
      nrd = 0;
      if (ack) begin
         nrd = (m_rd[m_qid] + 1) % m_len[m_qid];
         if (nrd == m_wr[m_qid]) ev[m_qid] |= 1;
         if (fetch_err) ev[m_qid] |= 4;
      end
      win = int'(reg_addr[9:5]);
      off = int'(reg_addr[4:0]);
      if (reg_we && win >= 1 && win <= NQ && off == 0 &&
          (m_ctrl[win-1] & 1) != 0 && reg_wdata[0] == 1'b0) ev[win-1] |= 2;
      if (ack) begin
         m_rd[m_qid] = nrd; m_req = 0; m_ptr = (m_qid + 1) % NQ;
      end else if (g >= 0) begin
         m_req = 1; m_qid = g;
      end
      for (int q = 0; q < NQ; q++)
         if (reg_we && win == q + 1 && off == 4) m_rsn[q] = ev[q];
         else m_rsn[q] = m_rsn[q] | ev[q];
      if (reg_we) begin
         if (win == 0 && off == 0)
            m_cnt = (reg_wdata == 0) ? 1 : (reg_wdata > NQ) ? NQ : int'(reg_wdata);
         else if (win >= 1 && win <= NQ) begin
            qq = win - 1;
            case (off)
               0:  m_ctrl[qq] = int'(reg_wdata & 32'd7);
               8:  m_len[qq] = (reg_wdata < 2) ? 2 : (reg_wdata > 32) ? 32 : int'(reg_wdata);
               16: if (reg_wdata < 32'(m_len[qq])) m_wr[qq] = int'(reg_wdata);
               24: m_base[qq][31:0] = reg_wdata;
               28: m_base[qq][63:32] = reg_wdata;
               default: ;
            endcase
         end
      end
   endtask

   initial m_reset();
   always @(posedge clk) if (!rst_n) m_reset(); else m_step();

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NQ-1:0] ei;
         n_chk++;
         if (fetch_req !== m_req) begin
            n_fail++;
            $display("FAIL R4: fetch_req got %0b expected %0b", fetch_req, m_req);
         end else if (m_req) begin
            if (int'(fetch_qid) != m_qid) begin
               n_fail++;
               $display("FAIL R8: fetch_qid got %0d expected %0d", fetch_qid, m_qid);
            end else if (fetch_addr !== m_base[m_qid] + 64'(m_rd[m_qid]) * 64'd32) begin
               n_fail++;
               $display("FAIL R4: fetch_addr got %h expected %h", fetch_addr,
                        m_base[m_qid] + 64'(m_rd[m_qid]) * 64'd32);
            end
         end
         for (int q = 0; q < NQ; q++)
            ei[q] = (q < m_cnt) && ((m_ctrl[q] & 2) != 0) && (m_rsn[q] != 0);
         n_chk++;
         if (irq !== ei) begin
            n_fail++;
            $display("FAIL R10: irq got %h expected %h", irq, ei);
         end
      end
   end

   // automatic acknowledge
   initial begin
      forever begin
         @(negedge clk);
         if (auto_ack) begin
            fetch_ack = fetch_req;
            fetch_err = fetch_req && err_pending;
            if (fetch_req) err_pending = 0;
         end
      end
   end

   // ---------------- tasks ----------------
   task automatic wreg(input logic [9:0] a, input logic [31:0] d);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic rchk(input logic [9:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a;
      #1;
      n_chk++;
      if (reg_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s: addr %h got %h expected %h", tag, a, reg_rdata, exp);
      end
   endtask

   task automatic bchk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic expect_grant(input int q, input bit err);
      while (!fetch_req) @(negedge clk);
      n_chk++;
      if (int'(fetch_qid) != q) begin
         n_fail++;
         $display("FAIL R8: grant to queue %0d expected %0d", fetch_qid, q);
      end
      fetch_ack = 1; fetch_err = err;
      @(negedge clk);
      fetch_ack = 0; fetch_err = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      rst_n = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
      fetch_ack = 0; fetch_err = 0;
      idle(3);
      rst_n = 1;
      idle(1);

      // R1 reset state
      rchk(10'h000, 32'd1, "R1 count");
      rchk(10'h020, 32'd0, "R1 ctrl");
      rchk(10'h028, 32'd32, "R1 length");
      rchk(10'h02C, 32'd0, "R1 read index");
      rchk(10'h024, 32'd0, "R1 status");
      bchk(fetch_req, 1'b0, "R1 fetch_req");
      bchk(|irq, 1'b0, "R1 irq");

      // R2 count clamping
      wreg(10'h000, 32'd0);  rchk(10'h000, 32'd1,  "R2 zero");
      wreg(10'h000, 32'd20); rchk(10'h000, 32'd16, "R2 above max");
      wreg(10'h000, 32'd4);  rchk(10'h000, 32'd4,  "R2 in range");

      // R6 length clamp and write-index bound
      wreg(10'h028, 32'd1);  rchk(10'h028, 32'd2,  "R6 length low");
      wreg(10'h028, 32'd40); rchk(10'h028, 32'd32, "R6 length high");
      wreg(10'h028, 32'd8);  rchk(10'h028, 32'd8,  "R6 length");
      wreg(10'h030, 32'd9);  rchk(10'h030, 32'd0,  "R6 wr above length");
      wreg(10'h030, 32'd8);  rchk(10'h030, 32'd0,  "R6 wr equal length");
      wreg(10'h030, 32'd3);  rchk(10'h030, 32'd3,  "R6 wr accepted");
      rchk(10'h024, 32'd0, "R7 not full");

      // R3 window map
      wreg(10'h038, 32'h0000_2000);
      wreg(10'h03C, 32'h0000_0010);
      wreg(10'h058, 32'hABCD_0000);
      rchk(10'h038, 32'h0000_2000, "R3 q0 base low");
      rchk(10'h03C, 32'h0000_0010, "R3 q0 base high");
      rchk(10'h058, 32'hABCD_0000, "R3 q1 base low");
      rchk(10'h05C, 32'h0000_0000, "R3 q1 base high untouched");

      // R4 first fetch, then R5/R9 drain
      wreg(10'h020, 32'd3);
      idle(1);
      bchk(fetch_req, 1'b1, "R4 request raised");
      n_chk++;
      if (fetch_addr !== 64'h0000_0010_0000_2000) begin
         n_fail++;
         $display("FAIL R4: fetch_addr got %h expected %h", fetch_addr, 64'h0000_0010_0000_2000);
      end
      auto_ack = 1;
      idle(12);
      rchk(10'h02C, 32'd3, "R5 read index advanced");
      rchk(10'h024, 32'h0100_0000, "R9 empty reason");
      bchk(irq[0], 1'b1, "R10 irq on empty");
      wreg(10'h024, 32'd0);
      rchk(10'h024, 32'h0000_0000, "R9 cleared");
      bchk(irq[0], 1'b0, "R10 irq after clear");

      // R9 stop code, R7 full, R11 stopped queue idle
      wreg(10'h020, 32'd2);
      wreg(10'h030, 32'd2);
      rchk(10'h024, 32'h0200_0001, "R7 full with stop reason");
      bchk(irq[0], 1'b1, "R10 irq on stop");
      idle(5);
      bchk(fetch_req, 1'b0, "R11 stopped queue not served");
      rchk(10'h02C, 32'd3, "R11 read index held");
      wreg(10'h030, 32'd1);
      rchk(10'h024, 32'h0200_0000, "R7 not full");
      wreg(10'h024, 32'd0);

      // R11 queue above count
      wreg(10'h0D0, 32'd1);
      wreg(10'h0C0, 32'd3);
      idle(8);
      bchk(fetch_req, 1'b0, "R11 queue above count idle");
      rchk(10'h0CC, 32'd0, "R11 read index untouched");
      bchk(irq[5], 1'b0, "R11 irq held low");
      wreg(10'h000, 32'd8);
      idle(6);
      rchk(10'h0CC, 32'd1, "R11 served after count raised");
      bchk(irq[5], 1'b1, "R10 irq queue 5");

      // R8 round-robin with manual acknowledge
      auto_ack = 0;
      fetch_ack = 0; fetch_err = 0;
      idle(1);
      wreg(10'h050, 32'd2);
      wreg(10'h070, 32'd2);
      wreg(10'h090, 32'd2);
      wreg(10'h040, 32'd1);
      wreg(10'h060, 32'd1);
      wreg(10'h080, 32'd1);
      expect_grant(1, 0);
      expect_grant(2, 0);
      expect_grant(3, 0);
      expect_grant(1, 0);
      expect_grant(2, 0);
      expect_grant(3, 0);
      idle(3);
      bchk(fetch_req, 1'b0, "R8 rings drained");

      // R9 error code, R10 enable bit
      wreg(10'h070, 32'd3);
      expect_grant(2, 1);
      idle(2);
      rchk(10'h064, 32'h0500_0000, "R9 error and empty");
      bchk(irq[2], 1'b0, "R10 irq disabled");
      wreg(10'h060, 32'd7);
      bchk(irq[2], 1'b1, "R10 irq enabled by 0x7");
      wreg(10'h060, 32'd0);
      bchk(irq[2], 1'b0, "R10 irq disabled by 0");
      rchk(10'h064, 32'h0700_0000, "R9 codes accumulate");

      idle(2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R4: watchdog expired, got running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule